// File: doc/BRIEF.md
# Five-Level Third-Order Noise Shaper

This block is the digital modulator at the end of a DAC path. It takes signed PCM samples that an upstream eight-times interpolation stage has already raised to 64 times the base rate. For each oversampled period it produces one of five output level codes. A third-order error-feedback loop shapes the quantization error, so that its spectrum goes as (1 - z^-1)^3 and is pushed away from the signal band. The level code drives a five-level analog reconstruction stage, which is outside this block.

The block runs on a system clock at 512 times the base rate. It derives its own update strobe with a divide-by-8 controller. The controller has two states. In ST_IDLE the divider is held at zero. The transition ST_IDLE -> ST_RUN is taken when `mod_en` is sampled high. In ST_RUN the divider counts 0..7 and fires one update on count 7. The transition ST_RUN -> ST_IDLE is taken when `mod_en` is sampled low. On each update the loop samples `pcm_in` and registers a new code, and `lvl_valid` is high for the following cycle. If the loop error exceeds a set limit, all loop state is cleared so that the modulator recovers from instability.

Top module: `ns5_shaper`

## Requirements
- R1: A synchronous active-high `rst` sets `lvl_code` to the mid code 2, drives `lvl_valid` low, clears all three error-state registers and returns the controller to ST_IDLE.
- R2: While `mod_en` is held high, `lvl_valid` pulses for exactly one cycle in every 8 clocks. The first pulse is seen in the cycle after the 9th rising edge that samples `mod_en` high.
- R3: While `mod_en` is low, `lvl_valid` stays low and `lvl_code` and the loop state hold. After re-enabling, the output sequence continues from the held state.
- R4: `lvl_code` is always in 0..4. Code k stands for the level (k - 2) * 2^(W-2), so full-scale input lies within the outer levels.
- R5: The quantizer output is the number of thresholds in {-3*2^(W-3), -2^(W-3), +2^(W-3), +3*2^(W-3)} that are less than or equal to the loop sum. A sum exactly on a threshold therefore takes the upper level, and values beyond the outer thresholds clip to code 0 or 4.
- R6: On each update the loop sum is u = x + 3*e1 - 3*e2 + e3, where x is `pcm_in` and e1..e3 are the last three errors (newest first). The new error is u minus the chosen level, and it shifts into e1.
- R7: If the new error's magnitude exceeds ERR_LIMIT, all three error registers are cleared instead of shifted. The code chosen in that update is still output.
- R8: Starting from reset, a constant-zero input gives code 2 on every update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at 512 times the base rate |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Run enable for the modulator and its divider |
| pcm_in | input | W (16) | Signed oversampled PCM sample, held stable by the upstream stage |
| lvl_code | output | 3 | Five-level output code, 0..4 |
| lvl_valid | output | 1 | One-cycle strobe marking a newly registered code |

## Verification
On every cycle, the assertions check these rules: the update strobe never fires on consecutive cycles or in ST_IDLE; `lvl_valid` follows each update; the code is stable between updates and stays within 0..4; the error registers stay within the limit and clear after an overflowing update; and a zero input with clear state gives the mid code. Only the bench scenarios can show bit-exact agreement with the arithmetic recurrence of R6. The same holds for tie and clipping behaviour at the exact threshold values, for recovery changing the later output sequence, for the first-pulse latency, and for the state being held across a disabled gap. The bench runs a second instance with a small error limit so that recovery is certain to occur.

// File: rtl/ns5_pkg.sv
package ns5_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rate_state_e;

    localparam int NUM_LEVELS = 5;
    localparam int NUM_THRESH = NUM_LEVELS - 1;
    localparam int MID_CODE   = 2;

endpackage

// File: rtl/ns5_rate_ctrl.sv
module ns5_rate_ctrl
    import ns5_pkg::*;
#(
    parameter int OSR_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic tick
);

    localparam int CW = (OSR_DIV > 2) ? $clog2(OSR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR_DIV - 1);

    rate_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (run_en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign tick = (state_q == ST_RUN) && (cnt_q == LAST);

    // R2: the update strobe is never wider than one cycle
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("update strobe fired on consecutive cycles");

    // R3: no update while the controller idles
    assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !tick)
        else $error("update strobe in idle state");

endmodule

// File: rtl/ns5_quantizer.sv
module ns5_quantizer
    import ns5_pkg::*;
#(
    parameter int W  = 16,
    parameter int WA = 21
) (
    input  logic signed [WA-1:0] u_sum,
    output logic        [2:0]    q_code
);

    localparam int HALF_STEP = 2 ** (W - 3);

    logic [NUM_THRESH-1:0] at_or_above;

    for (genvar i = 0; i < NUM_THRESH; i++) begin : g_thr
        localparam int THR_I = (2 * i - 3) * HALF_STEP;
        localparam logic signed [WA-1:0] THR = WA'(THR_I);
        assign at_or_above[i] = (u_sum >= THR);
    end

    always_comb begin
        q_code = 3'd0;
        for (int k = 0; k < NUM_THRESH; k++) begin
            q_code = q_code + {2'b00, at_or_above[k]};
        end
    end

endmodule

// File: rtl/ns5_errloop.sv
module ns5_errloop
    import ns5_pkg::*;
#(
    parameter int W     = 16,
    parameter int LIMIT = 32768,
    parameter int WE    = 17,
    parameter int WA    = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic signed [W-1:0]  din,
    input  logic        [2:0]    q_code,
    output logic signed [WA-1:0] u_sum,
    output logic        [2:0]    lvl_code,
    output logic                 lvl_valid
);

    localparam logic signed [WA-1:0] STEP  = WA'(2 ** (W - 2));
    localparam logic signed [WA-1:0] LIM_P = WA'(LIMIT);
    localparam logic signed [WA-1:0] LIM_N = WA'(-LIMIT);

    logic signed [WE-1:0] e1_q, e2_q, e3_q;
    logic        [2:0]    code_q;
    logic                 vld_q;

    logic signed [WA-1:0] x_ext, e1_x, e2_x, e3_x, lvl, err;
    logic                 err_ovf;

    always_comb begin
        x_ext = WA'(din);
        e1_x  = WA'(e1_q);
        e2_x  = WA'(e2_q);
        e3_x  = WA'(e3_q);
        u_sum = x_ext + (e1_x <<< 1) + e1_x - (e2_x <<< 1) - e2_x + e3_x;
        unique case (q_code)
            3'd0:    lvl = -(STEP <<< 1);
            3'd1:    lvl = -STEP;
            3'd2:    lvl = '0;
            3'd3:    lvl = STEP;
            3'd4:    lvl = STEP <<< 1;
            default: lvl = '0;
        endcase
        err     = u_sum - lvl;
        err_ovf = (err > LIM_P) || (err < LIM_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e1_q   <= '0;
            e2_q   <= '0;
            e3_q   <= '0;
            code_q <= 3'(MID_CODE);
            vld_q  <= 1'b0;
        end else begin
            vld_q <= tick;
            if (tick) begin
                code_q <= q_code;
                if (err_ovf) begin
                    e1_q <= '0;
                    e2_q <= '0;
                    e3_q <= '0;
                end else begin
                    e3_q <= e2_q;
                    e2_q <= e1_q;
                    e1_q <= WE'(err);
                end
            end
        end
    end

    assign lvl_code  = code_q;
    assign lvl_valid = vld_q;

    // R2: a valid strobe follows every update and nothing else
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> lvl_valid)
        else $error("missing valid after update");
    assert_valid_only_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !lvl_valid)
        else $error("valid without update");

    // R3: code holds between updates
    assert_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lvl_code))
        else $error("code changed without update");

    // R4: code stays within the five levels
    assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
        lvl_code <= 3'd4)
        else $error("code out of range");

    // R7: stored errors never exceed the limit
    assert_err_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        (WA'(e1_q) <= LIM_P) && (WA'(e1_q) >= LIM_N))
        else $error("error state beyond limit");

    // R7: an overflowing update clears all state
    assert_clear_on_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && err_ovf) |=> (e1_q == '0) && (e2_q == '0) && (e3_q == '0))
        else $error("state not cleared after overflow");

    // R8: zero input with clear state yields the mid code
    assert_zero_mid_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && din == '0 && e1_q == '0 && e2_q == '0 && e3_q == '0)
        |=> lvl_code == 3'(MID_CODE))
        else $error("zero input did not give mid code");

endmodule

// File: rtl/ns5_shaper.sv
module ns5_shaper
    import ns5_pkg::*;
#(
    parameter int W         = 16,
    parameter int OSR_DIV   = 8,
    parameter int ERR_LIMIT = 2 ** (W - 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mod_en,
    input  logic signed [W-1:0] pcm_in,
    output logic        [2:0]   lvl_code,
    output logic                lvl_valid
);

    localparam int WE   = $clog2(ERR_LIMIT) + 2;
    localparam int WMAX = (WE > W) ? WE : W;
    localparam int WA   = WMAX + 4;

    logic                 tick;
    logic signed [WA-1:0] u_sum;
    logic        [2:0]    q_code;

    ns5_rate_ctrl #(.OSR_DIV(OSR_DIV)) u_rate (
        .clk    (clk),
        .rst    (rst),
        .run_en (mod_en),
        .tick   (tick)
    );

    ns5_quantizer #(.W(W), .WA(WA)) u_quant (
        .u_sum  (u_sum),
        .q_code (q_code)
    );

    ns5_errloop #(.W(W), .LIMIT(ERR_LIMIT), .WE(WE), .WA(WA)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .din       (pcm_in),
        .q_code    (q_code),
        .u_sum     (u_sum),
        .lvl_code  (lvl_code),
        .lvl_valid (lvl_valid)
    );

endmodule

// File: tb/ns5_shaper_bench.sv
module ns5_shaper_bench;

    localparam int W       = 16;
    localparam int DIV     = 8;
    localparam int Q       = 2 ** (W - 2);
    localparam int LIM_A   = 2 ** (W - 1);
    localparam int LIM_B   = 4096;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               mod_en = 1'b0;
    logic signed [W-1:0] pcm_in = '0;
    logic [2:0]         code_a, code_b;
    logic               vld_a, vld_b;

    always #4 clk = ~clk;

    ns5_shaper #(.W(W), .OSR_DIV(DIV), .ERR_LIMIT(LIM_A)) u_ns5_shaper (
        .clk(clk), .rst(rst), .mod_en(mod_en), .pcm_in(pcm_in),
        .lvl_code(code_a), .lvl_valid(vld_a)
    );

    ns5_shaper #(.W(W), .OSR_DIV(DIV), .ERR_LIMIT(LIM_B)) u_ns5_shaper_rec (
        .clk(clk), .rst(rst), .mod_en(mod_en), .pcm_in(pcm_in),
        .lvl_code(code_b), .lvl_valid(vld_b)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int recov   = 0;
    int me [2][3];
    bit first   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int quant(input int u);
        int c = 0;
        for (int i = 0; i < 4; i++) if (u >= (2 * i - 3) * (Q / 2)) c++;
        return c;
    endfunction

    task automatic model(input int idx, input int x, input int lim, output int code);
        int u, err;
        u    = x + 3 * me[idx][0] - 3 * me[idx][1] + me[idx][2];
        code = quant(u);
        err  = u - (code - 2) * Q;
        if (err > lim || err < -lim) begin
            me[idx][0] = 0; me[idx][1] = 0; me[idx][2] = 0;
            if (idx == 1) recov++;
        end else begin
            me[idx][2] = me[idx][1];
            me[idx][1] = me[idx][0];
            me[idx][0] = err;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mod_en = 1'b0; pcm_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 2; i++) for (int j = 0; j < 3; j++) me[i][j] = 0;
    endtask

    task automatic start();
        @(negedge clk);
        mod_en = 1'b1;
        first  = 1'b1;
    endtask

    task automatic step(input int x, input string req);
        int ea, eb, gap;
        pcm_in = W'(x);
        model(0, x, LIM_A, ea);
        model(1, x, LIM_B, eb);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!vld_a && gap < 100);
        if (first) chk("R2 first latency", gap, DIV + 1);
        else       chk("R2 spacing", gap, DIV);
        first = 1'b0;
        chk(req, int'(code_a), ea);
        chk({req, " R7 instance"}, int'(code_b), eb);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int tv [12] = '{0, 8191, 8192, -8192, -8193, 24575, 24576,
                        -24576, -24577, 32767, -32768, 16384};
        int held;
        int r0;

        // R1: reset state
        do_reset();
        chk("R1 code", int'(code_a), 2);
        chk("R1 valid", int'(vld_a), 0);

        // R5 / R4: thresholds, ties and clipping from clean state
        foreach (tv[i]) begin
            do_reset();
            start();
            step(tv[i], "R5");
        end
        do_reset(); start(); step(8192, "R5");
        chk("R5 tie goes up", int'(code_a), 3);
        do_reset(); start(); step(-24577, "R5");
        chk("R4 clip low", int'(code_a), 0);

        // R8: zero input
        do_reset();
        start();
        for (int k = 0; k < 40; k++) begin
            step(0, "R8");
            chk("R8 mid", int'(code_a), 2);
        end

        // R6: DC levels
        for (int v = -12000; v <= 12000; v += 3000) begin
            do_reset();
            start();
            for (int k = 0; k < 24; k++) step(v, "R6 dc");
        end

        // R6: triangle ramp
        do_reset();
        start();
        begin
            int x = -20000;
            int d = 997;
            for (int k = 0; k < 300; k++) begin
                step(x, "R6 ramp");
                x += d;
                if (x > 20000 || x < -20000) begin d = -d; x += 2 * d; end
            end
        end

        // R7: explicit recovery case
        do_reset();
        start();
        r0 = recov;
        step(5000, "R7");
        step(0, "R7");
        chk("R7 small-limit instance cleared", int'(code_b), 2);
        chk("R7 default instance kept error", int'(code_a), 3);
        chk("R7 recovery occurred", int'(recov > r0), 1);

        // R7: large swings
        do_reset();
        start();
        for (int k = 0; k < 64; k++) step((k % 2 == 0) ? 30000 : -30000, "R7 swing");

        // R3: disable holds output and state
        do_reset();
        start();
        for (int k = 0; k < 5; k++) step(3000, "R3 pre");
        mod_en = 1'b0;
        held = int'(code_a);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k % 8 == 0) begin
                chk("R3 no valid", int'(vld_a), 0);
                chk("R3 code held", int'(code_a), held);
            end
        end
        start();
        for (int k = 0; k < 8; k++) step(3000, "R3 resume");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule